// File: doc/BRIEF.md
# DDR Mode Register Programming Sequencer

This block sits on the controller side of a DDR SDRAM interface. It turns a single start request into the load-mode-register traffic that brings up the device's delay-locked loop and its operating settings. When a start is accepted it captures the requested burst length, burst type, CAS latency and output drive strength. It then waits until the controller reports that all banks are idle and no burst is in progress. After that it issues three load-mode-register commands, spaced apart, on the command, address and bank-address pins.

The three writes go in a fixed order. The extended register is written first, with the DLL enabled and the chosen drive strength. The base register is written next with the DLL-reset bit set. The base register is written last in normal mode. After the last write the block counts clock cycles in which CKE is high. Until that count reaches the DLL lock wait, READ commands stay blocked. When the wait ends, a one-cycle done pulse is given and the read-permission level rises. That level stays high until the next accepted start.

Top module: `ddr_mrs_seq`

## Requirements
- R1: While reset is applied and whenever the sequencer is not busy, the bus carries NOP, which is chip-select low and RAS, CAS and WE high. Busy, done and read permission are all low after reset.
- R2: An accepted start moves the block to busy on the next cycle. No load command is issued until the bank-idle input is high. The first load command appears in the cycle after the first clock edge at which the bank-idle input is seen high.
- R3: The load commands come in this order: extended register with bank bits BA1,BA0 = 01, then base register with bank bits 00 and the DLL-reset bit set, then base register with bank bits 00 in normal mode. A load command has all four command pins low.
- R4: The extended-register word has A0 = 0, which enables the DLL, and A1 = 1 when reduced drive strength is requested and 0 for normal drive. All other address bits are zero.
- R5: Both base-register words carry burst length on A2..A0, burst type on A3 and CAS latency on A6..A4. The normal word has zeros on A7 and above. The DLL-reset word differs from it only in A8 = 1. No load command ever drives any other pattern on A7 and above.
- R6: Consecutive load commands start exactly TMRD cycles apart (default 2), with NOP on the bus in every cycle between them.
- R7: Read permission stays low until DLL_WAIT clock edges (default 200) with CKE high have passed after the normal-mode write. Edges with CKE low are not counted.
- R8: Done is high for exactly one cycle, the first cycle in which read permission is high. Read permission then stays high.
- R9: The settings are captured when the start is accepted. Changing the setting inputs, or pulsing start, while the block is busy has no effect on the commands or on the timing.
- R10: A start accepted while read permission is high begins a new sequence and drops read permission on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run the programming sequence |
| banks_idle_i | input | 1 | High when all banks are idle and no burst is active |
| cke_i | input | 1 | Level of CKE driven to the device |
| burst_len_i | input | 3 | Burst length code for A2..A0 |
| burst_type_i | input | 1 | Burst type bit for A3 |
| cas_lat_i | input | 3 | CAS latency code for A6..A4 |
| drive_reduced_i | input | 1 | 1 requests reduced output drive |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | Address bus carrying the register word |
| ba_o | output | 2 | Bank address, bit 0 is BA0 |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the sequence completes |
| read_allowed_o | output | 1 | READ commands permitted |

## Verification
Two events can land on the same clock edge. The first is a CKE-low cycle, which must pause the lock-wait counter. The second is the edge on which that counter would otherwise have run out. The bench drives CKE low partway through the wait, for a length set per vector. It then checks that read permission and the done pulse shift later by exactly the hole length, and no more. A second overlap is a start pulse, together with changed setting inputs, arriving while the sequence is busy. The bench judges it by the register words already on the bus and by an unchanged completion cycle.

// File: rtl/ddr_mrs_pkg.sv
package ddr_mrs_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_ARM,
      S_EXT,
      S_GAP1,
      S_RST,
      S_GAP2,
      S_NORM,
      S_LOCK,
      S_FIN,
      S_READY
   } seq_state_t;

   typedef enum logic [1:0] {
      LW_NONE,
      LW_EXT,
      LW_DLLRST,
      LW_NORM
   } load_kind_t;

   typedef struct packed {
      logic [2:0] cas_lat;
      logic       burst_type;
      logic [2:0] burst_len;
      logic       drive_reduced;
   } mrs_cfg_t;

   // command pin order: cs_n, ras_n, cas_n, we_n
   localparam logic [3:0] PIN_NOP  = 4'b0111;
   localparam logic [3:0] PIN_LOAD = 4'b0000;

   localparam int unsigned DLLRST_BIT = 8;

endpackage

// File: rtl/ddr_mrs_cnt.sv
module ddr_mrs_cnt #(
   parameter int unsigned LIMIT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic hit
);
   localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [W-1:0] LAST = W'(LIMIT - 1);

   logic [W-1:0] cnt_q;

   assign hit = en && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr || hit) begin
         cnt_q <= '0;
      end else if (en) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/ddr_mrs_word.sv
module ddr_mrs_word
   import ddr_mrs_pkg::*;
#(
   parameter int unsigned ADDR_W = 13
) (
   input  load_kind_t        kind,
   input  mrs_cfg_t          cfg,
   output logic [ADDR_W-1:0] addr,
   output logic [1:0]        ba
);
   localparam int unsigned LOW_W = 9;

   logic [LOW_W-1:0] low;

   always_comb begin
      low = '0;
      ba  = 2'b00;
      unique case (kind)
         LW_EXT: begin
            low[0] = 1'b0;
            low[1] = cfg.drive_reduced;
            ba     = 2'b01;
         end
         LW_DLLRST: begin
            low[6:0]          = {cfg.cas_lat, cfg.burst_type, cfg.burst_len};
            low[DLLRST_BIT]   = 1'b1;
         end
         LW_NORM: begin
            low[6:0] = {cfg.cas_lat, cfg.burst_type, cfg.burst_len};
         end
         default: begin
            low = '0;
         end
      endcase
   end

   assign addr[LOW_W-1:0] = low;

   generate
      if (ADDR_W > LOW_W) begin : g_pad
         assign addr[ADDR_W-1:LOW_W] = '0;
      end
   endgenerate
endmodule

// File: rtl/ddr_mrs_fsm.sv
module ddr_mrs_fsm
   import ddr_mrs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       banks_idle_i,
   input  logic       gap_hit,
   input  logic       lock_hit,
   output seq_state_t state,
   output logic       cfg_load
);
   seq_state_t nxt;

   always_comb begin
      nxt      = state;
      cfg_load = 1'b0;
      unique case (state)
         S_IDLE, S_READY, S_FIN: begin
            if (start_i) begin
               nxt      = S_ARM;
               cfg_load = 1'b1;
            end else if (state == S_FIN) begin
               nxt = S_READY;
            end
         end
         S_ARM:  if (banks_idle_i) nxt = S_EXT;
         S_EXT:  nxt = S_GAP1;
         S_GAP1: if (gap_hit) nxt = S_RST;
         S_RST:  nxt = S_GAP2;
         S_GAP2: if (gap_hit) nxt = S_NORM;
         S_NORM: nxt = S_LOCK;
         S_LOCK: if (lock_hit) nxt = S_FIN;
         default: nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= S_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/ddr_mrs_seq.sv
module ddr_mrs_seq
   import ddr_mrs_pkg::*;
#(
   parameter int unsigned ADDR_W   = 13,
   parameter int unsigned TMRD     = 2,
   parameter int unsigned DLL_WAIT = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              banks_idle_i,
   input  logic              cke_i,
   input  logic [2:0]        burst_len_i,
   input  logic              burst_type_i,
   input  logic [2:0]        cas_lat_i,
   input  logic              drive_reduced_i,
   output logic              cs_n_o,
   output logic              ras_n_o,
   output logic              cas_n_o,
   output logic              we_n_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [1:0]        ba_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              read_allowed_o
);
   localparam int unsigned GAP_CYC = TMRD - 1;

   generate
      if (ADDR_W < 9) begin : g_bad_addr
         $error("ADDR_W must reach the DLL-reset bit");
      end
      if (TMRD < 2) begin : g_bad_tmrd
         $error("TMRD must be at least 2");
      end
      if (DLL_WAIT < 1) begin : g_bad_wait
         $error("DLL_WAIT must be at least 1");
      end
   endgenerate

   seq_state_t state;
   logic       cfg_load, gap_hit, lock_hit;
   mrs_cfg_t   cfg_q;
   load_kind_t kind;
   logic [3:0] pins;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (cfg_load) begin
         cfg_q <= '{cas_lat: cas_lat_i, burst_type: burst_type_i,
                    burst_len: burst_len_i, drive_reduced: drive_reduced_i};
      end
   end

   ddr_mrs_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .banks_idle_i (banks_idle_i),
      .gap_hit      (gap_hit),
      .lock_hit     (lock_hit),
      .state        (state),
      .cfg_load     (cfg_load)
   );

   ddr_mrs_cnt #(.LIMIT(GAP_CYC)) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!(state == S_GAP1 || state == S_GAP2)),
      .en    (1'b1),
      .hit   (gap_hit)
   );

   ddr_mrs_cnt #(.LIMIT(DLL_WAIT)) u_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state != S_LOCK),
      .en    (cke_i),
      .hit   (lock_hit)
   );

   always_comb begin
      unique case (state)
         S_EXT:   kind = LW_EXT;
         S_RST:   kind = LW_DLLRST;
         S_NORM:  kind = LW_NORM;
         default: kind = LW_NONE;
      endcase
   end

   ddr_mrs_word #(.ADDR_W(ADDR_W)) u_word (
      .kind (kind),
      .cfg  (cfg_q),
      .addr (addr_o),
      .ba   (ba_o)
   );

   assign pins = (kind == LW_NONE) ? PIN_NOP : PIN_LOAD;
   assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = pins;

   assign busy_o = (state != S_IDLE) && (state != S_FIN) && (state != S_READY);
   assign done_o = (state == S_FIN);
   assign read_allowed_o = (state == S_FIN) || (state == S_READY);
endmodule

// File: rtl/ddr_mrs_seq_chk.sv
module ddr_mrs_seq_chk #(
   parameter int unsigned ADDR_W = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n_o,
   input logic              ras_n_o,
   input logic              cas_n_o,
   input logic              we_n_o,
   input logic [ADDR_W-1:0] addr_o,
   input logic [1:0]        ba_o,
   input logic              busy_o,
   input logic              done_o,
   input logic              read_allowed_o
);
   logic is_load, is_nop;
   assign is_load = ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0000);
   assign is_nop  = ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111);

   // R6
   load_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_load |=> is_nop);

   // R5
   reserved_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_load |-> (addr_o[ADDR_W-1:7] == '0 || addr_o[ADDR_W-1:7] == (ADDR_W-7)'(2)));

   // R3
   dll_reset_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_load && addr_o[8]) |-> (ba_o == 2'b00));

   // R1
   quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> is_nop);

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> read_allowed_o);

   // R7
   read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      read_allowed_o |-> !busy_o);
endmodule

bind ddr_mrs_seq ddr_mrs_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cs_n_o         (cs_n_o),
   .ras_n_o        (ras_n_o),
   .cas_n_o        (cas_n_o),
   .we_n_o         (we_n_o),
   .addr_o         (addr_o),
   .ba_o           (ba_o),
   .busy_o         (busy_o),
   .done_o         (done_o),
   .read_allowed_o (read_allowed_o)
);

// File: tb/ddr_mrs_seq_bench.sv
`timescale 1ns/1ps
module ddr_mrs_seq_bench;
   localparam int ADDR_W = 13;
   localparam int TMRD   = 2;

   typedef struct packed {
      logic [2:0] cl;
      logic       bt;
      logic [2:0] bl;
      logic       drv;
      logic [7:0] idle_dly;
      logic [7:0] hole;
      logic [9:0] exp_ready;
   } vec_t;

   // ready cycle = 207 + idle delay + CKE hole (R2, R7)
   localparam vec_t VEC [4] = '{
      '{3'd2, 1'b0, 3'd1, 1'b0, 8'd0, 8'd0,  10'd207},
      '{3'd3, 1'b1, 3'd3, 1'b1, 8'd5, 8'd0,  10'd212},
      '{3'd6, 1'b1, 3'd2, 1'b0, 8'd0, 8'd12, 10'd219},
      '{3'd3, 1'b0, 3'd3, 1'b1, 8'd3, 8'd7,  10'd217}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic start_i = 1'b0, banks_idle_i = 1'b0, cke_i = 1'b1;
   logic [2:0] burst_len_i = '0, cas_lat_i = '0;
   logic burst_type_i = 1'b0, drive_reduced_i = 1'b0;
   logic cs_n_o, ras_n_o, cas_n_o, we_n_o;
   logic [ADDR_W-1:0] addr_o;
   logic [1:0] ba_o;
   logic busy_o, done_o, read_allowed_o;

   int n_chk = 0, n_fail = 0, cyc = 0;

   always #2.5 clk = ~clk;

   ddr_mrs_seq u_ddr_mrs_seq (.*);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run(input vec_t v, input bit poke);
      int lt[3];
      logic [ADDR_W-1:0] la[3];
      logic [1:0] lb[3];
      int nload = 0, bad_nop = 0, ready_t = 0, bad_res = 0;
      logic ra_t1 = 1'b1, busy_t1 = 1'b0, done_at = 1'b0, done_after = 1'b1, ra_after = 1'b0;
      int d = int'(v.idle_dly);
      int h = int'(v.hole);
      logic [ADDR_W-1:0] e_norm, e_rst, e_ext;
      e_norm = ADDR_W'({v.cl, v.bt, v.bl});
      e_rst  = e_norm | (ADDR_W'(1) << 8);
      e_ext  = ADDR_W'({v.drv, 1'b0});
      @(negedge clk);
      {cas_lat_i, burst_type_i, burst_len_i, drive_reduced_i} = {v.cl, v.bt, v.bl, v.drv};
      start_i = 1'b1;
      banks_idle_i = (d == 0);
      cke_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int t = 1; t <= 480; t++) begin
         if (t > 1) @(negedge clk);
         if (t == 1) begin ra_t1 = read_allowed_o; busy_t1 = busy_o; end
         if ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0000) begin
            if (nload < 3) begin lt[nload] = t; la[nload] = addr_o; lb[nload] = ba_o; end
            if (!(addr_o[ADDR_W-1:7] == '0 || addr_o[ADDR_W-1:7] == 6'b000010)) bad_res++;
            nload++;
         end else if ({cs_n_o, ras_n_o, cas_n_o, we_n_o} != 4'b0111) begin
            bad_nop++;
         end
         if (ready_t != 0 && t == ready_t + 1) begin
            done_after = done_o; ra_after = read_allowed_o;
            break;
         end
         if (read_allowed_o && ready_t == 0) begin ready_t = t; done_at = done_o; end
         banks_idle_i = (t >= d + 1);
         cke_i = !(t >= 50 && t < 50 + h);
         if (poke && t == 3)
            {cas_lat_i, burst_type_i, burst_len_i, drive_reduced_i} = ~{v.cl, v.bt, v.bl, v.drv};
         start_i = poke && (t == 100);
      end
      start_i = 1'b0;
      chk(busy_t1 == 1'b1, "R2 busy after start", int'(busy_t1), 1);
      chk(ra_t1 == 1'b0, "R10 read permission drops on start", int'(ra_t1), 0);
      chk(nload == 3, "R3 load count", nload, 3);
      if (nload >= 3) begin
         chk(lt[0] == 2 + d, "R2 first load cycle", lt[0], 2 + d);
         chk({lb[0], lb[1], lb[2]} == 6'b010000, "R3 bank order", int'({lb[0], lb[1], lb[2]}), 'h10);
         chk(la[0] == e_ext, "R4 extended word", int'(la[0]), int'(e_ext));
         chk(la[1] == e_rst, poke ? "R9 R5 dll reset word" : "R5 dll reset word", int'(la[1]), int'(e_rst));
         chk(la[2] == e_norm, poke ? "R9 R5 normal word" : "R5 normal word", int'(la[2]), int'(e_norm));
         chk(lt[1] - lt[0] == TMRD && lt[2] - lt[1] == TMRD, "R6 spacing", lt[2] - lt[0], 2 * TMRD);
      end
      chk(bad_nop == 0, "R6 NOP between loads", bad_nop, 0);
      chk(bad_res == 0, "R5 reserved upper bits", bad_res, 0);
      chk(ready_t == int'(v.exp_ready), poke ? "R9 R7 ready cycle" : "R7 ready cycle", ready_t, int'(v.exp_ready));
      chk(done_at == 1'b1, "R8 done with ready", int'(done_at), 1);
      chk(done_after == 1'b0 && ra_after == 1'b1, "R8 done single, ready held",
          int'({done_after, ra_after}), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111, "R1 NOP in reset",
          int'({cs_n_o, ras_n_o, cas_n_o, we_n_o}), 7);
      chk({busy_o, done_o, read_allowed_o} == 3'b000, "R1 flags in reset",
          int'({busy_o, done_o, read_allowed_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_o == 1'b0 && read_allowed_o == 1'b0, "R1 idle after reset",
          int'({busy_o, read_allowed_o}), 0);

      for (int i = 0; i < 4; i++) run(VEC[i], 1'b0);
      // R9 settings captured, start ignored while busy; R10 restart from ready
      run(VEC[1], 1'b1);

      // R1 reset during a sequence returns to a quiet bus
      @(negedge clk);
      start_i = 1'b1; banks_idle_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (20) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk({busy_o, read_allowed_o, cs_n_o, ras_n_o, cas_n_o, we_n_o} == 6'b000111,
          "R1 mid-run reset", int'({busy_o, read_allowed_o, cs_n_o, ras_n_o, cas_n_o, we_n_o}), 7);
      rst_n = 1'b1;
      @(negedge clk);
      run(VEC[0], 1'b0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule